// File: doc/BRIEF.md
# Upper-Address Short-Code Allocator

This block shrinks the instruction addresses that travel down a pipeline. Every fetch address is cut into a wide upper field (the top 40 bits) and a narrow lower field (the bottom 24 bits). A small table of eight entries records which upper fields are currently in flight. Each entry is reached by a 3-bit code. Downstream stages carry only the 27-bit tag {code, lower field}. When a stage needs the whole address back, the expand port rebuilds it from the tag.

A fetch whose upper field is already in the table reuses that entry's code and adds one to the entry's reference count. A fetch with a new upper field claims the lowest-numbered free entry. If all eight entries are in use, the fetch is stalled. Each retire names a code and drops one reference from it. An entry returns to the free pool when its count reaches zero. A flush empties the whole table at once, for use after a full pipeline drain.

Each entry is a two-state machine:
- FREE and LIVE are the two states.
- CLAIM moves an entry from FREE to LIVE with a count of one.
- HOLD keeps an entry LIVE while its count moves up or down.
- RELEASE moves an entry from LIVE to FREE when the last reference retires.
- WIPE forces any entry to FREE on a flush.

The fetch answer is combinational, in the same cycle as the request. Table updates take effect at the next clock edge.

Top module: `hicode_alloc`

## Requirements
- R1: A granted fetch returns `fetch_tag` = {code, fetch_addr[23:0]}. The code is in bits 26:24 and the lower field is in bits 23:0.
- R2: A fetch whose upper field fetch_addr[63:24] matches a LIVE entry is granted in the same cycle with that entry's code, without stalling, and adds one to the entry's count.
- R3: A fetch whose upper field matches no LIVE entry claims the lowest-numbered FREE entry, which becomes LIVE with a count of one.
- R4: A fetch with an unmatched upper field while all eight entries are LIVE raises `fetch_stall`, keeps `fetch_grant` low and changes no entry. For any valid fetch, exactly one of grant and stall is high.
- R5: A retire takes one from the count of the named code. When the count reaches zero, the entry reads FREE from the next cycle and can be claimed in that cycle.
- R6: A granted hit and a retire on the same code in the same cycle leave that code's count unchanged.
- R7: `expand_addr` = {upper field of entry expand_tag[26:24], expand_tag[23:0]} combinationally. `expand_live` is high exactly when that entry is LIVE.
- R8: While `flush` is high no fetch is granted. After a flush cycle every entry is FREE with a count of zero.
- R9: After reset every entry is FREE.
- R10: A hit on an entry whose count is at its maximum (15 with the default count width of 4) is stalled and leaves the count unchanged.
- R11: A retire that names a FREE entry is ignored, and the entry stays FREE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Frees every entry and clears every count |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 64 | Full instruction address of the fetch |
| fetch_grant | output | 1 | Fetch accepted; `fetch_tag` is valid |
| fetch_stall | output | 1 | Fetch refused this cycle |
| fetch_tag | output | 27 | Compressed tag {code, lower field} |
| retire_valid | input | 1 | One reference is released |
| retire_code | input | 3 | Code whose reference is released |
| expand_tag | input | 27 | Tag to be expanded |
| expand_addr | output | 64 | Rebuilt full address |
| expand_live | output | 1 | The code in `expand_tag` is LIVE |

## Verification
The assertions assume that a retire only names a code for which an earlier granted fetch is still outstanding. If that does not hold, counts drain early, although the table itself stays consistent. They also assume that `fetch_addr` is held stable across the combinational answer within a cycle.

The reference model in the bench retires only codes it holds as LIVE. The single exception is a dedicated step that retires a FREE code on purpose. In the random phase, upper fields are drawn from a pool of ten values, so that hits, new claims and full-table stalls all occur often. Flushes in that phase are rare.

// File: rtl/hca_pkg.sv
package hca_pkg;
    typedef enum logic {
        ENT_FREE = 1'b0,
        ENT_LIVE = 1'b1
    } ent_state_e;
endpackage

// File: rtl/hca_entry.sv
module hca_entry
    import hca_pkg::*;
#(
    parameter int HIGH_W = 40,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              claim,
    input  logic              inc,
    input  logic              dec,
    input  logic [HIGH_W-1:0] upper_in,
    output ent_state_e        state_q,
    output logic [HIGH_W-1:0] upper_q,
    output logic [CNT_W-1:0]  cnt_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ent_state_e        state_d;
    logic [HIGH_W-1:0] upper_d;
    logic [CNT_W-1:0]  cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ENT_FREE;
            upper_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            upper_q <= upper_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        upper_d = upper_q;
        cnt_d   = cnt_q;
        if (flush) begin
            // WIPE
            state_d = ENT_FREE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ENT_FREE: begin
                    // CLAIM; a retire on a free entry is ignored
                    if (claim) begin
                        state_d = ENT_LIVE;
                        upper_d = upper_in;
                        cnt_d   = ONE;
                    end
                end
                ENT_LIVE: begin
                    // HOLD, or RELEASE on the last reference
                    if (inc && !dec) begin
                        cnt_d = cnt_q + ONE;
                    end else if (dec && !inc) begin
                        cnt_d = cnt_q - ONE;
                        if (cnt_q == ONE) state_d = ENT_FREE;
                    end
                end
                default: state_d = ENT_FREE;
            endcase
        end
    end
endmodule

// File: rtl/hca_match.sv
module hca_match #(
    parameter int ENTRIES = 8,
    parameter int CODE_W  = 3,
    parameter int HIGH_W  = 40,
    parameter int CNT_W   = 4
) (
    input  logic [ENTRIES-1:0]        live,
    input  logic [ENTRIES*HIGH_W-1:0] upper_flat,
    input  logic [ENTRIES*CNT_W-1:0]  cnt_flat,
    input  logic [HIGH_W-1:0]         key,
    output logic                      hit,
    output logic [CODE_W-1:0]         hit_code,
    output logic                      hit_full,
    output logic                      free_any,
    output logic [CODE_W-1:0]         free_code
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Scan downwards so the lowest index wins both searches.
    always_comb begin
        hit       = 1'b0;
        hit_code  = '0;
        hit_full  = 1'b0;
        free_any  = 1'b0;
        free_code = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (live[i] && upper_flat[i*HIGH_W +: HIGH_W] == key) begin
                hit      = 1'b1;
                hit_code = CODE_W'(i);
                hit_full = (cnt_flat[i*CNT_W +: CNT_W] == CNT_MAX);
            end
            if (!live[i]) begin
                free_any  = 1'b1;
                free_code = CODE_W'(i);
            end
        end
    end
endmodule

// File: rtl/hicode_alloc.sv
module hicode_alloc
    import hca_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LOW_W  = 24,
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     fetch_valid,
    input  logic [ADDR_W-1:0]        fetch_addr,
    output logic                     fetch_grant,
    output logic                     fetch_stall,
    output logic [CODE_W+LOW_W-1:0]  fetch_tag,
    input  logic                     retire_valid,
    input  logic [CODE_W-1:0]        retire_code,
    input  logic [CODE_W+LOW_W-1:0]  expand_tag,
    output logic [ADDR_W-1:0]        expand_addr,
    output logic                     expand_live
);
    localparam int HIGH_W  = ADDR_W - LOW_W;
    localparam int ENTRIES = 1 << CODE_W;
    localparam int TAG_W   = CODE_W + LOW_W;

    logic [HIGH_W-1:0]         key;
    logic [ENTRIES-1:0]        live_vec;
    logic [ENTRIES*HIGH_W-1:0] upper_flat;
    logic [ENTRIES*CNT_W-1:0]  cnt_flat;
    logic                      hit, hit_full, free_any;
    logic [CODE_W-1:0]         hit_code, free_code, code_sel, exp_code;

    assign key = fetch_addr[ADDR_W-1:LOW_W];

    hca_match #(
        .ENTRIES(ENTRIES), .CODE_W(CODE_W), .HIGH_W(HIGH_W), .CNT_W(CNT_W)
    ) u_match (
        .live      (live_vec),
        .upper_flat(upper_flat),
        .cnt_flat  (cnt_flat),
        .key       (key),
        .hit       (hit),
        .hit_code  (hit_code),
        .hit_full  (hit_full),
        .free_any  (free_any),
        .free_code (free_code)
    );

    always_comb begin
        fetch_grant = fetch_valid && !flush && (hit ? !hit_full : free_any);
        fetch_stall = fetch_valid && !fetch_grant;
        code_sel    = hit ? hit_code : free_code;
        fetch_tag   = {code_sel, fetch_addr[LOW_W-1:0]};
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        ent_state_e        st;
        logic [HIGH_W-1:0] up;
        logic [CNT_W-1:0]  cnt;

        hca_entry #(.HIGH_W(HIGH_W), .CNT_W(CNT_W)) u_ent (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .claim   (fetch_grant && !hit && free_code == CODE_W'(g)),
            .inc     (fetch_grant && hit && hit_code == CODE_W'(g)),
            .dec     (retire_valid && retire_code == CODE_W'(g)),
            .upper_in(key),
            .state_q (st),
            .upper_q (up),
            .cnt_q   (cnt)
        );

        assign live_vec[g]                    = (st == ENT_LIVE);
        assign upper_flat[g*HIGH_W +: HIGH_W] = up;
        assign cnt_flat[g*CNT_W +: CNT_W]     = cnt;
    end

    always_comb begin
        exp_code    = expand_tag[TAG_W-1:LOW_W];
        expand_addr = {upper_flat[exp_code*HIGH_W +: HIGH_W], expand_tag[LOW_W-1:0]};
        expand_live = live_vec[exp_code];
    end
endmodule

// File: rtl/hicode_alloc_chk.sv
module hicode_alloc_chk #(
    parameter int ADDR_W = 64,
    parameter int LOW_W  = 24,
    parameter int CODE_W = 3,
    parameter int CNT_W  = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          flush,
    input logic                          fetch_valid,
    input logic [ADDR_W-1:0]             fetch_addr,
    input logic                          fetch_grant,
    input logic                          fetch_stall,
    input logic [CODE_W+LOW_W-1:0]       fetch_tag,
    input logic                          retire_valid,
    input logic [CODE_W-1:0]             retire_code,
    input logic [(1<<CODE_W)-1:0]        live_vec,
    input logic [(1<<CODE_W)*CNT_W-1:0]  cnt_flat
);
    localparam int TAG_W = CODE_W + LOW_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    logic [CODE_W-1:0] tag_code;
    logic [CNT_W-1:0]  tag_cnt, ret_cnt;

    always_comb begin
        tag_code = fetch_tag[TAG_W-1:LOW_W];
        tag_cnt  = cnt_flat[tag_code*CNT_W +: CNT_W];
        ret_cnt  = cnt_flat[retire_code*CNT_W +: CNT_W];
    end

    p_low_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> fetch_tag[LOW_W-1:0] == fetch_addr[LOW_W-1:0]);

    p_claim_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |=> live_vec[$past(tag_code)]);

    p_grant_stall_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fetch_grant && fetch_stall));

    p_valid_answered_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |-> (fetch_grant || fetch_stall));

    p_last_release_frees_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && retire_valid && ret_cnt == ONE && live_vec[retire_code]
         && !(fetch_grant && tag_code == retire_code))
        |=> !live_vec[$past(retire_code)]);

    p_flush_no_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !fetch_grant);

    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> live_vec == '0);

    p_sat_no_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_grant |-> tag_cnt != CNT_MAX);
endmodule

bind hicode_alloc hicode_alloc_chk #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .fetch_grant (fetch_grant),
    .fetch_stall (fetch_stall),
    .fetch_tag   (fetch_tag),
    .retire_valid(retire_valid),
    .retire_code (retire_code),
    .live_vec    (live_vec),
    .cnt_flat    (cnt_flat)
);

// File: tb/hicode_alloc_tb.sv
module hicode_alloc_tb;
    localparam int CMAX = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [63:0] fetch_addr = '0;
    logic        fetch_grant, fetch_stall;
    logic [26:0] fetch_tag;
    logic        retire_valid = 1'b0;
    logic [2:0]  retire_code = '0;
    logic [26:0] expand_tag = '0;
    logic [63:0] expand_addr;
    logic        expand_live;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    int          mcnt [8];
    logic [39:0] mup  [8];

    always #4 clk = ~clk;   // 125 MHz

    hicode_alloc u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .fetch_grant(fetch_grant), .fetch_stall(fetch_stall), .fetch_tag(fetch_tag),
        .retire_valid(retire_valid), .retire_code(retire_code),
        .expand_tag(expand_tag), .expand_addr(expand_addr), .expand_live(expand_live)
    );

    task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, compare before posedge, advance model after it.
    task automatic step(input string rq, input bit fv, input logic [63:0] fa,
                        input bit rv, input int rc, input bit fl, input logic [26:0] et);
        bit eg;
        int code;
        bit hit;
        @(negedge clk);
        fetch_valid  = fv;
        fetch_addr   = fa;
        retire_valid = rv;
        retire_code  = 3'(rc);
        flush        = fl;
        expand_tag   = et;
        #2;
        hit = 1'b0; code = -1; eg = 1'b0;
        for (int i = 0; i < 8; i++)
            if (!hit && mcnt[i] > 0 && mup[i] == fa[63:24]) begin hit = 1'b1; code = i; end
        if (!hit)
            for (int i = 7; i >= 0; i--) if (mcnt[i] == 0) code = i;
        if (fv && !fl) eg = hit ? (mcnt[code] < CMAX) : (code >= 0);
        chk(rq, "grant", 64'(fetch_grant), 64'(eg));
        chk(rq, "stall", 64'(fetch_stall), 64'(fv && !eg));
        if (eg) chk(rq, "tag", 64'(fetch_tag), 64'({3'(code), fa[23:0]}));
        chk(rq, "expand_live", 64'(expand_live), 64'(mcnt[et[26:24]] > 0));
        if (mcnt[et[26:24]] > 0)
            chk(rq, "expand_addr", expand_addr, {mup[et[26:24]], et[23:0]});
        @(posedge clk);
        if (fl) begin
            for (int i = 0; i < 8; i++) mcnt[i] = 0;
        end else begin
            if (eg) begin
                if (!hit) mup[code] = fa[63:24];
                mcnt[code]++;
            end
            if (rv && mcnt[rc] > 0) mcnt[rc]--;
        end
    endtask

    function automatic logic [63:0] mk(input int hi, input int lo);
        return {40'(64'h0000_00A0_0000 + hi), 24'(lo)};
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin mcnt[i] = 0; mup[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9: all free after reset
        for (int c = 0; c < 8; c++) step("R9", 0, '0, 0, 0, 0, {3'(c), 24'h0});
        // R3 / R1: eight new upper fields take codes 0..7
        for (int k = 0; k < 8; k++) step("R3", 1, mk(k, 24'h100 + k), 0, 0, 0, {3'(k), 24'h55});
        // R4: ninth distinct upper stalls
        step("R4", 1, mk(20, 7), 0, 0, 0, 27'h0);
        step("R4", 1, mk(21, 9), 0, 0, 0, {3'd7, 24'hABCDEF});
        // R2: hit on code 3
        step("R2", 1, mk(3, 24'hFFFFFF), 0, 0, 0, {3'd3, 24'h123456});
        // R5: last retire of code 5 frees it, then it is reclaimed
        step("R5", 0, '0, 1, 5, 0, {3'd5, 24'h1});
        step("R5", 1, mk(30, 24'h42), 0, 0, 0, {3'd5, 24'h2});
        step("R5", 0, '0, 0, 0, 0, {3'd5, 24'h3});
        // R6: hit and retire on code 3 together (count 2 stays 2)
        step("R6", 1, mk(3, 1), 1, 3, 0, {3'd3, 24'h0});
        step("R6", 0, '0, 1, 3, 0, {3'd3, 24'h0});
        step("R6", 0, '0, 1, 3, 0, {3'd3, 24'h0});
        step("R6", 0, '0, 0, 0, 0, {3'd3, 24'h9});
        // R10: saturate code 0 (count 1 -> 15), then one more stalls
        for (int k = 0; k < CMAX; k++) step("R10", 1, mk(0, k), 0, 0, 0, {3'd0, 24'(k)});
        step("R10", 1, mk(0, 77), 0, 0, 0, {3'd0, 24'h77});
        // R8: flush with a fetch present
        step("R8", 1, mk(1, 5), 0, 0, 1, {3'd1, 24'h5});
        for (int c = 0; c < 8; c++) step("R8", 0, '0, 0, 0, 0, {3'(c), 24'h0});
        // R11: retire on a free code is ignored
        step("R11", 0, '0, 1, 2, 0, {3'd2, 24'h0});
        step("R11", 1, mk(40, 1), 0, 0, 0, {3'd2, 24'h0});
        step("R11", 1, mk(41, 1), 0, 0, 0, {3'd2, 24'h0});
        step("R11", 0, '0, 0, 0, 0, {3'd1, 24'h3});
        // R7 and R2: random traffic over a small upper pool
        for (int n = 0; n < 3000; n++) begin
            int rc;
            bit rv;
            rc = 0;
            rv = 1'b0;
            for (int t = 0; t < 4 && !rv; t++) begin
                rc = int'($urandom_range(0, 7));
                if (mcnt[rc] > 0 && $urandom_range(0, 1) == 1) rv = 1'b1;
            end
            step("R7", $urandom_range(0, 3) != 0, mk(int'($urandom_range(0, 9)), int'($urandom)),
                 rv, rc, $urandom_range(0, 199) == 0, 27'($urandom));
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule